// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Detector

This block watches a vector of already synchronized general-purpose input lines and turns per-line trigger conditions into interrupt status. Each line is configured independently with three bits: a sense bit, a dual-edge bit and an event bit. Together they choose between level and edge triggering and set the active polarity. Edge conditions are latched until software clears them. Level conditions track the pin directly.

The raw status vector reports every line's condition regardless of whether the line is enabled. A per-line enable byte masks that vector into the masked status. The OR of the masked bits drives a single interrupt line toward an interrupt controller.

Bus decoding is outside the block. A register front end feeds it the configuration bytes and a clear strobe that carries a byte of write data, in which a 1 bit clears that line's latched edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: With sense=1 and event=1, a line's raw status equals its pin in the same cycle: high pin gives 1, low pin gives 0.
- R2: With sense=1 and event=0, a line's raw status is the inverse of its pin in the same cycle.
- R3: With sense=0, dual=0 and event=1, a 0-to-1 change of the pin between two consecutive clock samples sets the raw status bit from that clock edge onward, and it stays set after the pin returns low.
- R4: With sense=0, dual=0 and event=0, a 1-to-0 pin change sets the raw status bit at that clock edge, and it stays set until cleared.
- R5: With sense=0 and dual=1, a change in either direction sets the raw status bit and the event bit has no effect. With sense=1 the dual bit has no effect.
- R6: A clock edge where the clear strobe is high and write-data bit i is 1 clears line i's latched edge status unless R7 applies. A 0 data bit, or a data byte with the strobe low, leaves it unchanged.
- R7: When a new qualifying edge and a clear of the same line occur at the same clock edge, the status bit ends up set.
- R8: Masked status equals raw status AND the enable vector, bit by bit, in the same cycle.
- R9: The interrupt output is 1 exactly when any masked status bit is 1. It is never 1 while the enable vector is zero.
- R10: Changing a line's sense, dual or event bit does not clear an edge status that is already latched. If the line is returned to edge sensing before any clear, the latched bit reappears.
- R11: While reset is asserted and after its release, all latched edge bits are 0 and every line's previous pin sample is taken as 0. With edge sensing selected and all pins low, raw status, masked status and the interrupt output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_LINES | Synchronized input lines |
| sense_i | input | NUM_LINES | 1 = level sensing, 0 = edge sensing |
| dual_edge_i | input | NUM_LINES | 1 = both edges trigger (edge sensing only) |
| event_i | input | NUM_LINES | 1 = high level / rising edge, 0 = low level / falling edge |
| irq_en_i | input | NUM_LINES | Per-line interrupt enable |
| clr_stb_i | input | 1 | Clear write strobe |
| clr_data_i | input | NUM_LINES | Clear write data, 1 clears that line |
| raw_stat_o | output | NUM_LINES | Raw status per line |
| mask_stat_o | output | NUM_LINES | Raw status AND enable |
| irq_o | output | 1 | OR of masked status |

## Verification
The bench builds the block with the default NUM_LINES of 8. This is small enough that every line moves through all eight combinations of sense, dual and event while it is driven with dense pseudo-random pin, enable and clear patterns. The configuration of each line rotates during the run, so latched edges survive mode changes, and clears can collide with fresh edges on any line. Directed steps at the end force the same-cycle edge-and-clear case and clears written with 0 data bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef struct packed {
    logic level_sense;
    logic dual_edge;
    logic act_high;
  } line_cfg_t;

  function automatic logic edge_match(line_cfg_t cfg, logic cur, logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (cfg.dual_edge) return rise | fall;
    return cfg.act_high ? rise : fall;
  endfunction

endpackage

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  line_cfg_t cfg_i,
  input  logic      clr_i,
  output logic      raw_o
);

  logic pin_q;
  logic lat_q;
  logic set_now;

  assign set_now = ~cfg_i.level_sense & edge_match(cfg_i, pin_i, pin_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      // set has priority over a coincident clear
      lat_q <= set_now | (lat_q & ~clr_i);
    end
  end

  assign raw_o = cfg_i.level_sense ? (pin_i == cfg_i.act_high) : lat_q;

  assert_latch_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !clr_i) |=> lat_q);

  assert_clear_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_now) |=> !lat_q);

  assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_now) |=> lat_q);

  assert_set_needs_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lat_q) |-> (pin_q != $past(pin_q)));

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] raw_i,
  input  logic [NUM_LINES-1:0] en_i,
  output logic [NUM_LINES-1:0] masked_o,
  output logic                 irq_o
);

  assign masked_o = raw_i & en_i;
  assign irq_o    = |masked_o;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [NUM_LINES-1:0] sense_i,
  input  logic [NUM_LINES-1:0] dual_edge_i,
  input  logic [NUM_LINES-1:0] event_i,
  input  logic [NUM_LINES-1:0] irq_en_i,
  input  logic                 clr_stb_i,
  input  logic [NUM_LINES-1:0] clr_data_i,
  output logic [NUM_LINES-1:0] raw_stat_o,
  output logic [NUM_LINES-1:0] mask_stat_o,
  output logic                 irq_o
);

  logic [NUM_LINES-1:0] clr_vec;

  assign clr_vec = clr_data_i & {NUM_LINES{clr_stb_i}};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_cfg_t cfg;
    assign cfg = '{level_sense: sense_i[g], dual_edge: dual_edge_i[g], act_high: event_i[g]};

    gpio_irq_line i_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[g]),
      .cfg_i  (cfg),
      .clr_i  (clr_vec[g]),
      .raw_o  (raw_stat_o[g])
    );
  end

  gpio_irq_combine #(.NUM_LINES(NUM_LINES)) i_combine (
    .raw_i    (raw_stat_o),
    .en_i     (irq_en_i),
    .masked_o (mask_stat_o),
    .irq_o    (irq_o)
  );

  assert_irq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|irq_en_i));

endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] pin = '0, sense = '0, dual = '0, evt = '0, en = '0, clr_data = '0;
  logic         clr_stb = 1'b0;
  logic [N-1:0] raw, msk;
  logic         irq;

  gpio_irq_detect #(.NUM_LINES(N)) i_gpio_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sense_i(sense), .dual_edge_i(dual),
    .event_i(evt), .irq_en_i(en), .clr_stb_i(clr_stb), .clr_data_i(clr_data),
    .raw_stat_o(raw), .mask_stat_o(msk), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  logic [N-1:0] m_lat = '0, m_prev = '0;
  logic [2:0]   m_cfg [N];

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] p, logic [N-1:0] s, logic [N-1:0] d, logic [N-1:0] e,
                      logic [N-1:0] ie, logic cs, logic [N-1:0] cd);
    logic [N-1:0] hit, exp_raw;
    logic [N-1:0] chg;
    @(negedge clk);
    pin = p; sense = s; dual = d; evt = e; en = ie; clr_stb = cs; clr_data = cd;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      chg[i] = (m_cfg[i] != {s[i], d[i], e[i]});
      m_cfg[i] = {s[i], d[i], e[i]};
      if (d[i]) hit[i] = p[i] ^ m_prev[i];
      else if (e[i]) hit[i] = p[i] & ~m_prev[i];
      else hit[i] = ~p[i] & m_prev[i];
      hit[i] = hit[i] & ~s[i];
    end
    m_lat  = hit | (m_lat & ~(cd & {N{cs}}));
    m_prev = p;
    #1;
    for (int i = 0; i < N; i++) begin
      string tag;
      exp_raw[i] = s[i] ? (p[i] == e[i]) : m_lat[i];
      if (chg[i]) tag = "R10";
      else if (cs && cd[i] && hit[i]) tag = "R7";
      else if (cs && cd[i]) tag = "R6";
      else if (s[i]) tag = e[i] ? "R1" : "R2";
      else if (d[i]) tag = "R5";
      else tag = e[i] ? "R3" : "R4";
      chk($sformatf("%s line %0d", tag, i), N'(raw[i]), N'(exp_raw[i]));
    end
    chk("R8 masked", msk, exp_raw & ie);
    chk("R9 irq", N'(irq), N'(|(exp_raw & ie)));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] s, d, e;
    for (int i = 0; i < N; i++) m_cfg[i] = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 raw in reset", raw, '0);
    chk("R11 irq in reset", N'(irq), '0);
    @(negedge clk);
    rst_n = 1'b1;
    step('0, '0, '0, '0, '1, 1'b0, '0);
    chk("R11 raw after reset", raw, '0);

    for (int st = 0; st < 640; st++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = (i * 3 + st / 40) % 8;
        s[i] = c[2]; d[i] = c[1]; e[i] = c[0];
      end
      step(N'(st * 37) ^ N'(st >> 3), s, d, e, N'(st * 29) ^ N'(8'hA5),
           (st % 3) == 0, N'(st * 91 + 5));
    end

    // directed: rising edge on all lines, edge and clear together, then clears
    step('0, '0, '0, '1, '1, 1'b1, '1);
    chk("R6 cleared all", raw, '0);
    step('1, '0, '0, '1, '1, 1'b1, '1);
    chk("R7 edge beats clear", raw, '1);
    step('1, '0, '0, '1, '1, 1'b1, '0);
    chk("R6 zero data keeps", raw, '1);
    step('1, '0, '0, '1, '1, 1'b0, '1);
    chk("R6 no strobe keeps", raw, '1);
    step('1, '0, '0, '1, '0, 1'b0, '0);
    chk("R9 no enable no irq", N'(irq), '0);
    step('1, '0, '0, '1, '1, 1'b1, 8'h0F);
    chk("R6 partial clear", raw, 8'hF0);
    finish_run();
  end
endmodule